// File: doc/BRIEF.md
# SAR Converter Serial Port Controller

This block is the digital side of a 10-bit successive-approximation converter's three-wire port. A host drives an active-low conversion strobe and a serial clock. Both are brought into a faster system clock through synchronizers, and the block acts on their edges. A falling strobe captures the parallel sample and sub-bit inputs, which stand in for the analog front end, and starts a 16-period output frame. In that frame the data pin is driven on each serial-clock rising edge.

The block has no mode register. The power state is set by where the strobe returns high, counted against the serial-clock rising edges of the current frame. An early return puts the block into partial power-down and a second one into full power-down. A late return keeps the output driven so the next frame can follow at once. The block also reports whether the input is being tracked, whether the reference may be on, and whether the first conversion after reset (a calibration pass) is still pending. A parameter selects straight-binary or two's-complement coding of the data field.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset the output is undriven (`sdo_oe`=0, `sdo`=0), `pwr_mode` is 0 (normal), `tracking`=1, `ref_on`=1 and `cal_busy`=1.
- R2: A strobe falling edge captures `sample_code` and `sub_code`, drives the output low and clears `tracking`.
- R3: After the n-th serial-clock rising edge of a frame (n = 1..16), `sdo` shows bit 16-n of the word {three zeros, data field MSB first, sub_code[1], sub_code[0], one zero}. The data MSB therefore appears after the 4th rising edge.
- R4: If the strobe rises after the 14th rising edge and before the 16th, the frame completes, `pwr_mode` becomes 0, and the output stays driven after the 16th falling edge until the next strobe fall.
- R5: If the strobe rises after the 3rd to 13th rising edge while in normal mode, `pwr_mode` becomes 1 (partial) and the output is released at once.
- R6: The same early rise while in partial mode sets `pwr_mode` to 2 (full). `ref_on` is 0 only in full mode.
- R7: A power-down mode returns to normal only after the strobe has been held low for at least 14 rising edges, at the strobe rise or at the release described in R8.
- R8: If the strobe is still low at the 16th falling edge, the output stays driven until the next serial-clock rising edge or strobe rising edge, whichever comes first. At that edge the output is released.
- R9: `tracking` returns to 1 at the 14th rising edge of a frame.
- R10: `cal_busy` clears at the 16th rising edge of the first frame after reset and is never set again, including when leaving a power-down mode.
- R11: With BIPOLAR=0 the data field equals `sample_code`. With BIPOLAR=1 the data field has the MSB of `sample_code` inverted, which turns offset binary into two's complement.
- R12: A strobe rise before the 3rd rising edge abandons the frame: the output is released, `tracking` is set and `pwr_mode` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Conversion strobe; falling edge starts a frame |
| ser_clk | input | 1 | Serial clock from the host |
| sample_code | input | DATA_W | Parallel conversion result standing in for the analog core |
| sub_code | input | SUB_W | Two sub-bits appended after the data field |
| sdo | output | 1 | Serial data, forced to 0 while undriven |
| sdo_oe | output | 1 | Output enable for the data pin |
| pwr_mode | output | 2 | 0 normal, 1 partial power-down, 2 full power-down |
| tracking | output | 1 | Input tracking flag |
| ref_on | output | 1 | Reference enable flag |
| cal_busy | output | 1 | First-conversion calibration still pending |

## Verification
The assertions assume the host never moves the strobe and the serial clock within the same synchronizer window. They also assume each level is held for at least two system clocks, so that every edge is seen alone and in order. The stimulus holds every level for four system clocks and changes only one input at a time, on the falling system-clock edge. The sample inputs change only while the strobe is high and no frame is running.

// File: rtl/sar_serial_pkg.sv
`timescale 1ns/1ps
package sar_serial_pkg;

    localparam int DATA_W_DEF = 10;
    localparam int SUB_W_DEF  = 2;
    localparam int LEAD_Z_DEF = 3;
    localparam int CNT_W_DEF  = 5;
    localparam int SYNC_DEF   = 2;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'd0,
        PM_PARTIAL = 2'd1,
        PM_FULL    = 2'd2
    } pmode_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_CONV = 2'd1,
        FS_HOLD = 2'd2,
        FS_WREL = 2'd3
    } fstate_t;

    // current and previous synchronized level of one input
    typedef struct packed {
        logic cur;
        logic prev;
    } sync_t;

    function automatic logic rising(input sync_t s);
        return s.cur & ~s.prev;
    endfunction

    function automatic logic falling(input sync_t s);
        return ~s.cur & s.prev;
    endfunction

    function automatic pmode_t deepen(input pmode_t m);
        return (m == PM_NORMAL) ? PM_PARTIAL : PM_FULL;
    endfunction

endpackage

// File: rtl/sar_edge_sync.sv
`timescale 1ns/1ps
module sar_edge_sync
    import sar_serial_pkg::*;
#(
    parameter int STAGES  = SYNC_DEF,
    parameter bit RST_VAL = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output sync_t sync
);

    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {(STAGES+1){RST_VAL}};
        end else begin
            chain <= {chain[STAGES-1:0], din};
        end
    end

    always_comb begin
        sync.cur  = chain[STAGES-1];
        sync.prev = chain[STAGES];
    end

endmodule

// File: rtl/sar_frame_fsm.sv
`timescale 1ns/1ps
module sar_frame_fsm
    import sar_serial_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int FRAME_LEN = 16,
    parameter int PD_EDGE   = 3,
    parameter int CONT_EDGE = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_t            st_s,
    input  sync_t            sc_s,
    output logic             load,
    output logic             shift,
    output logic             drive,
    output pmode_t           mode,
    output logic             track,
    output logic             cal,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] C_PD    = CNT_W'(PD_EDGE);
    localparam logic [CNT_W-1:0] C_CONT  = CNT_W'(CONT_EDGE);

    fstate_t          state;
    logic [CNT_W-1:0] cnt_nxt;
    logic             st_fall, st_rise, sc_rise, sc_fall;

    always_comb begin
        st_fall = falling(st_s);
        st_rise = rising(st_s);
        sc_rise = rising(sc_s);
        sc_fall = falling(sc_s);
        cnt_nxt = cnt + 1'b1;
        load    = st_fall;
        shift   = (state == FS_CONV) && !st_fall && sc_rise && (cnt < C_FRAME);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            cnt   <= '0;
            mode  <= PM_NORMAL;
            drive <= 1'b0;
            track <= 1'b1;
            cal   <= 1'b1;
        end else if (st_fall) begin
            state <= FS_CONV;
            cnt   <= '0;
            drive <= 1'b1;
            track <= 1'b0;
        end else begin
            case (state)
                FS_CONV: begin
                    if (sc_rise) begin
                        if (cnt < C_FRAME) begin
                            cnt <= cnt_nxt;
                            if (cnt_nxt == C_CONT)  track <= 1'b1;
                            if (cnt_nxt == C_FRAME) cal   <= 1'b0;
                        end
                    end else if (sc_fall && cnt == C_FRAME) begin
                        state <= st_s.cur ? FS_HOLD : FS_WREL;
                    end else if (st_rise) begin
                        if (cnt >= C_CONT) begin
                            mode <= PM_NORMAL;
                        end else begin
                            state <= FS_IDLE;
                            drive <= 1'b0;
                            track <= 1'b1;
                            if (cnt >= C_PD) mode <= deepen(mode);
                        end
                    end
                end
                FS_WREL: begin
                    if (sc_rise || st_rise) begin
                        state <= FS_IDLE;
                        drive <= 1'b0;
                        mode  <= PM_NORMAL;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sar_shift_out.sv
`timescale 1ns/1ps
module sar_shift_out #(
    parameter int DATA_W  = 10,
    parameter int SUB_W   = 2,
    parameter int LEAD_Z  = 3,
    parameter bit BIPOLAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] code,
    input  logic [SUB_W-1:0]  sub,
    output logic              bit_q
);

    localparam int FRAME_LEN = LEAD_Z + DATA_W + SUB_W + 1;

    logic [DATA_W-1:0]    code_fmt;
    logic [FRAME_LEN-1:0] word_q;

    generate
        if (BIPOLAR) begin : g_twos
            assign code_fmt = {~code[DATA_W-1], code[DATA_W-2:0]};
        end else begin : g_straight
            assign code_fmt = code;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            bit_q  <= 1'b0;
        end else if (load) begin
            word_q <= {{LEAD_Z{1'b0}}, code_fmt, sub, 1'b0};
            bit_q  <= 1'b0;
        end else if (shift) begin
            bit_q  <= word_q[FRAME_LEN-1];
            word_q <= {word_q[FRAME_LEN-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/sar_serial_ctrl.sv
`timescale 1ns/1ps
module sar_serial_ctrl
    import sar_serial_pkg::*;
#(
    parameter int DATA_W      = DATA_W_DEF,
    parameter int SUB_W       = SUB_W_DEF,
    parameter int LEAD_Z      = LEAD_Z_DEF,
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    parameter bit BIPOLAR     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic              ser_clk,
    input  logic [DATA_W-1:0] sample_code,
    input  logic [SUB_W-1:0]  sub_code,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [1:0]        pwr_mode,
    output logic              tracking,
    output logic              ref_on,
    output logic              cal_busy
);

    localparam int FRAME_LEN = LEAD_Z + DATA_W + SUB_W + 1;
    localparam int PD_EDGE   = LEAD_Z;
    localparam int CONT_EDGE = FRAME_LEN - SUB_W;

    sync_t            st_s, sc_s;
    pmode_t           mode_q;
    logic             load, shift, drive, bit_q;
    logic [CNT_W-1:0] rise_cnt;

    sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_strobe (
        .clk(clk), .rst(rst), .din(strobe_n), .sync(st_s)
    );

    sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .din(ser_clk), .sync(sc_s)
    );

    sar_frame_fsm #(
        .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN),
        .PD_EDGE(PD_EDGE), .CONT_EDGE(CONT_EDGE)
    ) u_fsm (
        .clk(clk), .rst(rst), .st_s(st_s), .sc_s(sc_s),
        .load(load), .shift(shift), .drive(drive), .mode(mode_q),
        .track(tracking), .cal(cal_busy), .cnt(rise_cnt)
    );

    sar_shift_out #(
        .DATA_W(DATA_W), .SUB_W(SUB_W), .LEAD_Z(LEAD_Z), .BIPOLAR(BIPOLAR)
    ) u_shift (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .code(sample_code), .sub(sub_code), .bit_q(bit_q)
    );

    assign sdo      = bit_q & drive;
    assign sdo_oe   = drive;
    assign pwr_mode = mode_q;
    assign ref_on   = (mode_q != PM_FULL);

endmodule

// File: rtl/sar_serial_ctrl_chk.sv
`timescale 1ns/1ps
module sar_serial_ctrl_chk
    import sar_serial_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int FRAME_LEN = 16,
    parameter int CONT_EDGE = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             sdo,
    input logic             sdo_oe,
    input logic [1:0]       pwr_mode,
    input logic             tracking,
    input logic             ref_on,
    input logic             cal_busy,
    input logic [CNT_W-1:0] rise_cnt
);

    p_start_drives_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> (!sdo && !tracking));

    p_frame_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(rise_cnt) <= FRAME_LEN);

    p_partial_releases_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == PM_PARTIAL && $past(pwr_mode) == PM_NORMAL) |-> !sdo_oe);

    p_full_via_partial_r6: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == PM_FULL && $past(pwr_mode) != PM_FULL)
        |-> ($past(pwr_mode) == PM_PARTIAL && !ref_on));

    p_wake_needs_edges_r7: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == PM_NORMAL && $past(pwr_mode) != PM_NORMAL)
        |-> (int'($past(rise_cnt)) >= CONT_EDGE));

    p_track_resume_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(tracking) && sdo_oe) |-> (int'(rise_cnt) == CONT_EDGE));

    p_cal_once_r10: assert property (@(posedge clk) disable iff (rst)
        !cal_busy |=> !cal_busy);

endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(
    .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN), .CONT_EDGE(CONT_EDGE)
) u_chk (
    .clk(clk), .rst(rst), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_mode(pwr_mode),
    .tracking(tracking), .ref_on(ref_on), .cal_busy(cal_busy),
    .rise_cnt(rise_cnt)
);

// File: tb/sar_serial_ctrl_bench.sv
`timescale 1ns/1ps
module sar_serial_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic [9:0] code = '0;
    logic [1:0] sub = '0;

    logic       sdo_u, oe_u, trk_u, ref_u, cal_u;
    logic [1:0] mode_u;
    logic       sdo_b, oe_b, trk_b, ref_b, cal_b;
    logic [1:0] mode_b;

    int checks = 0;
    int fails  = 0;
    logic [15:0] cap_u, cap_b;

    always #4 clk = ~clk;

    sar_serial_ctrl #(.BIPOLAR(1'b0)) u_sar_serial_ctrl (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .ser_clk(ser_clk),
        .sample_code(code), .sub_code(sub), .sdo(sdo_u), .sdo_oe(oe_u),
        .pwr_mode(mode_u), .tracking(trk_u), .ref_on(ref_u), .cal_busy(cal_u)
    );

    sar_serial_ctrl #(.BIPOLAR(1'b1)) u_sar_serial_ctrl_bip (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .ser_clk(ser_clk),
        .sample_code(code), .sub_code(sub), .sdo(sdo_b), .sdo_oe(oe_b),
        .pwr_mode(mode_b), .tracking(trk_b), .ref_on(ref_b), .cal_busy(cal_b)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] frame_of(input logic [9:0] c, input logic [1:0] s, input bit bip);
        logic [9:0] f;
        f = c;
        if (bip) f[9] = ~c[9];
        return {3'b000, f, s, 1'b0};
    endfunction

    // behavioural reference, acting on inputs seen two and three clocks back
    logic [3:0]  hs, hc;
    int          m_state, m_n, m_mode;
    logic        m_oe, m_su, m_sb, m_trk, m_cal;
    logic [15:0] w_u, w_b;

    always @(posedge clk) begin
        if (rst) begin
            hs = 4'b1111; hc = 4'b0000;
            m_state = 0; m_n = 0; m_mode = 0;
            m_oe = 0; m_su = 0; m_sb = 0; m_trk = 1; m_cal = 1;
        end else begin
            bit cf, cr, sr, sf;
            hs = {hs[2:0], strobe_n};
            hc = {hc[2:0], ser_clk};
            cf = !hs[2] && hs[3];
            cr = hs[2] && !hs[3];
            sr = hc[2] && !hc[3];
            sf = !hc[2] && hc[3];
            if (cf) begin
                m_state = 1; m_n = 0; m_oe = 1; m_su = 0; m_sb = 0; m_trk = 0;
                w_u = frame_of(code, sub, 1'b0);
                w_b = frame_of(code, sub, 1'b1);
            end else if (m_state == 1) begin
                if (sr) begin
                    if (m_n < 16) begin
                        m_n = m_n + 1;
                        m_su = w_u[16-m_n];
                        m_sb = w_b[16-m_n];
                        if (m_n == 14) m_trk = 1;
                        if (m_n == 16) m_cal = 0;
                    end
                end else if (sf && m_n == 16) begin
                    m_state = hs[2] ? 2 : 3;
                end else if (cr) begin
                    if (m_n >= 14) m_mode = 0;
                    else begin
                        m_state = 0; m_oe = 0; m_trk = 1;
                        if (m_n >= 3) m_mode = (m_mode == 0) ? 1 : 2;
                    end
                end
            end else if (m_state == 3 && (sr || cr)) begin
                m_state = 0; m_oe = 0; m_mode = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R3",  "sdo vs model",      sdo_u, m_oe ? m_su : 1'b0);
            check("R11", "bipolar sdo model", sdo_b, m_oe ? m_sb : 1'b0);
            check("R8",  "sdo_oe vs model",   oe_u,  m_oe);
            check("R5",  "mode vs model",     mode_u, m_mode);
            check("R9",  "tracking vs model", trk_u, m_trk);
            check("R6",  "ref_on vs model",   ref_u, m_mode != 2);
            check("R10", "cal vs model",      cal_u, m_cal);
        end
    end

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic strobe(input bit v);
        strobe_n = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            cap_u = {cap_u[14:0], sdo_u};
            cap_b = {cap_b[14:0], sdo_b};
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // continuous-style frame: strobe rises between 14th and 16th edge
    task automatic cont_frame(input logic [9:0] c, input logic [1:0] s);
        code = c; sub = s; cap_u = '0; cap_b = '0;
        strobe(1'b0);
        pulses(14);
        strobe(1'b1);
        pulses(2);
        check("R3",  "unipolar frame word", cap_u, frame_of(c, s, 1'b0));
        check("R11", "bipolar frame word",  cap_b, frame_of(c, s, 1'b1));
        check("R4",  "driven after frame",  oe_u, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run hung actual=1 expected=0");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "reset oe",    oe_u, 0);
        check("R1", "reset sdo",   sdo_u, 0);
        check("R1", "reset mode",  mode_u, 0);
        check("R1", "reset track", trk_u, 1);
        check("R1", "reset ref",   ref_u, 1);
        check("R1", "reset cal",   cal_u, 1);

        // first frame = calibration pass, with step-wise checks
        code = 10'h2A5; sub = 2'b10; cap_u = '0; cap_b = '0;
        strobe(1'b0);
        check("R2", "start drives", oe_u, 1);
        check("R2", "start low",    sdo_u, 0);
        check("R2", "start hold",   trk_u, 0);
        pulses(13);
        check("R9", "still holding at 13", trk_u, 0);
        pulses(1);
        check("R9",  "tracking at 14", trk_u, 1);
        check("R10", "cal pending at 14", cal_u, 1);
        strobe(1'b1);
        pulses(2);
        check("R3",  "first frame word", cap_u, frame_of(10'h2A5, 2'b10, 1'b0));
        check("R3",  "msb at 4th edge",  cap_u[12], 1);
        check("R11", "bipolar word",     cap_b, frame_of(10'h2A5, 2'b10, 1'b1));
        check("R10", "cal cleared", cal_u, 0);
        check("R4",  "still driven", oe_u, 1);
        check("R4",  "mode normal",  mode_u, 0);

        // strobe held low through the 16th fall, released by sclk
        code = 10'h13C; sub = 2'b01; cap_u = '0;
        strobe(1'b0);
        pulses(16);
        check("R3", "frame word 2", cap_u, frame_of(10'h13C, 2'b01, 1'b0));
        check("R8", "driven until next edge", oe_u, 1);
        pulses(1);
        check("R8", "released by sclk", oe_u, 0);
        strobe(1'b1);

        // same, released by strobe rise
        strobe(1'b0);
        pulses(16);
        strobe(1'b1);
        check("R8", "released by strobe", oe_u, 0);

        // partial then full power-down
        strobe(1'b0); pulses(4); strobe(1'b1);
        check("R5", "partial entered", mode_u, 1);
        check("R5", "partial hi-z",    oe_u, 0);
        check("R6", "ref on in partial", ref_u, 1);
        strobe(1'b0); pulses(8); strobe(1'b1);
        check("R6", "full entered", mode_u, 2);
        check("R6", "ref off in full", ref_u, 0);
        strobe(1'b0); pulses(2); strobe(1'b1);
        check("R12", "early rise keeps mode", mode_u, 2);
        check("R12", "early rise releases", oe_u, 0);
        check("R12", "early rise tracks",   trk_u, 1);

        // wake with exactly 14 edges
        strobe(1'b0); pulses(14); strobe(1'b1);
        check("R7",  "woke to normal", mode_u, 0);
        check("R7",  "ref back on", ref_u, 1);
        check("R10", "cal not re-armed", cal_u, 0);
        pulses(2);
        check("R4",  "driven after wake frame", oe_u, 1);

        // window boundaries: 13 edges -> partial, 3 edges -> full
        strobe(1'b0); pulses(13); strobe(1'b1);
        check("R5", "13 edges partial", mode_u, 1);
        strobe(1'b0); pulses(3); strobe(1'b1);
        check("R6", "3 edges full", mode_u, 2);
        strobe(1'b0); pulses(16);
        check("R7", "still full before release", mode_u, 2);
        pulses(1);
        check("R7", "release wakes", mode_u, 0);
        check("R8", "release hi-z",  oe_u, 0);
        strobe(1'b1);

        // early abort from normal
        strobe(1'b0); pulses(2); strobe(1'b1);
        check("R12", "normal abort mode", mode_u, 0);
        check("R12", "normal abort hi-z", oe_u, 0);

        // data coding extremes
        cont_frame(10'h000, 2'b00);
        cont_frame(10'h3FF, 2'b11);
        cont_frame(10'h200, 2'b01);
        cont_frame(10'h1FF, 2'b10);

        repeat (10) @(negedge clk);
        report();
    end

endmodule